// File: doc/BRIEF.md
# Depth-Cascade Token Steering Controller

This controller sits beside the storage array of one FIFO slice and decides, cycle by cycle, whether that slice takes part in a shared write or a shared read. Several identical slices can be placed on a common write strobe, a common read strobe and a common data bus. Linked into a ring, they behave as a single queue whose depth is the sum of the slice depths. Each slice stores and returns every word exactly once.

The slice's role is captured while reset is held. The role is taken from two pins: the expansion input and the lead-select pin. In the cascaded roles, one write token and one read token travel around the ring. When a slice uses its last location, it drops the matching token. On the following cycle it drives its expansion output low for one cycle, with a kind bit that says which token is being passed. The next slice treats that low level as ownership in the same cycle, so a strobe in that cycle is not lost.

In the standalone role, the slice owns both tokens permanently. Its shared output pin carries the active-low half-full indication, and the lead-select pin acts as a rewind request for the read pointer.

Top module: `cascade_token_ctrl`

## Requirements
- R1: While rst_n is low, `mode` latches from the pins. `xi_n` low gives standalone (2'd0). `xi_n` high with `lead_n` low gives cascade head (2'd1). `xi_n` high with `lead_n` high gives cascade tail (2'd2).
- R2: After reset is released, `mode` holds its latched value whatever `xi_n` and `lead_n` do.
- R3: One cycle after any reset cycle, `xo_hf_n` is high in the cascade roles. While rst_n is low, `wr_en` and `rd_en` stay low even when the strobes are high.
- R4: After reset, a head slice owns both tokens, a tail slice owns neither, and a standalone slice owns both.
- R5: The local enables are the shared strobe ANDed with ownership of the matching token. Across a ring, exactly one slice enables for each write strobe and exactly one for each read strobe.
- R6: In a cascade role, a write at pointer DEPTH-1 drops the write token. The slice then drives `xo_hf_n` low with `xo_kind`=1 in the next cycle only.
- R7: In a cascade role, a read at pointer DEPTH-1 drops the read token. The slice then drives `xo_hf_n` low with `xo_kind`=0 in the next cycle.
- R8: A cascade slice that sees `xi_n` low owns the token named by `xi_kind` (1 = write, 0 = read) in that same cycle and keeps it afterwards. Words therefore leave the ring in the order they were written.
- R9: When one slice drops both tokens in the same cycle, the write hand-off (`xo_kind`=1) goes out first and the read hand-off (`xo_kind`=0) follows in the next cycle.
- R10: In standalone, both enables follow the strobes and both pointers wrap from DEPTH-1 to 0. `xo_hf_n` equals the inverse of `half_full`, and no hand-off pulse is produced.
- R11: In standalone, `lead_n` low for a cycle sets `rd_ptr` to 0, taking precedence over a read in that cycle, and leaves `wr_ptr` unchanged.
- R12: In a cascade role, `lead_n` and `half_full` have no effect after reset: the read pointer does not rewind, and `xo_hf_n` stays high outside hand-offs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; role pins are sampled while low |
| xi_n | input | 1 | Expansion input: role pin during reset, hand-off pulse (active low) afterwards |
| xi_kind | input | 1 | Kind of incoming hand-off: 1 write token, 0 read token |
| lead_n | input | 1 | Lead select during reset; rewind request in standalone |
| wr_stb | input | 1 | Shared write strobe, one cycle per word |
| rd_stb | input | 1 | Shared read strobe, one cycle per word |
| half_full | input | 1 | Half-full state from the local flag logic |
| wr_en | output | 1 | Local write enable |
| rd_en | output | 1 | Local read enable |
| wr_ptr | output | AW | Local write address |
| rd_ptr | output | AW | Local read address |
| xo_hf_n | output | 1 | Hand-off pulse (cascade) or active-low half-full (standalone) |
| xo_kind | output | 1 | Kind of outgoing hand-off |
| mode | output | 2 | Latched role: 0 standalone, 1 head, 2 tail |

## Verification
The bench builds a ring of three slices with DEPTH=4, so a token goes all the way round after twelve words. Both hand-off directions, the wrap back to the head and the same-cycle collision of the two hand-offs are all reached within a few dozen cycles. A fourth instance, also with DEPTH=4, is held in the standalone role. On that instance, pointer wrap, rewind and the half-full pin are driven directly, and the role pins are moved after reset to show that the latched role does not change.

// File: rtl/cascade_pkg.sv
// Shared types for the depth-cascade token controller.
// Assumes nothing beyond a two-bit role encoding.
package cascade_pkg;

    typedef enum logic [1:0] {
        ROLE_ALONE = 2'd0,
        ROLE_HEAD  = 2'd1,
        ROLE_TAIL  = 2'd2
    } slice_role_e;

    // Map the two role pins to a role; low expansion input means standalone
    function automatic slice_role_e decode_role(input logic xi_n, input logic lead_n);
        if (!xi_n)       return ROLE_ALONE;
        else if (!lead_n) return ROLE_HEAD;
        else             return ROLE_TAIL;
    endfunction

endpackage

// File: rtl/cascade_role_latch.sv
// Captures the slice role from the role pins on every reset cycle and holds
// it once reset is released. Also offers the role the pins imply right now,
// so token owners can load their reset state in the same cycle.
// Assumes rst_n is synchronous and active low.
module cascade_role_latch
    import cascade_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        xi_n,
    input  logic        lead_n,
    output slice_role_e role_q,
    output slice_role_e role_pins
);

    // Decode the pins continuously
    always_comb role_pins = decode_role(xi_n, lead_n);

    // Track the pins while in reset, freeze afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) role_q <= role_pins;
    end

    // R2
    role_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(role_q));

endmodule

// File: rtl/token_slot.sv
// One token owner with its local address pointer. Used once for writes and
// once for reads. In a cascade role, using the last location drops the token
// and raises a one-cycle hand-off request. An incoming token counts as owned
// in the cycle it arrives. Assumes DEPTH >= 2 and that the caller already
// gates `take` with the cascade roles.
module token_slot #(
    parameter int DEPTH = 2048,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cascade,
    input  logic          reset_own,
    input  logic          rewind,
    input  logic          stb,
    input  logic          take,
    output logic          en,
    output logic [AW-1:0] ptr,
    output logic          handoff
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic own_q;

    // Local enable: strobe qualified by held or arriving ownership
    always_comb en = rst_n && stb && (own_q || take);

    // Hand-off request when the last location is used in a cascade role
    always_comb handoff = en && cascade && (ptr == LAST);

    // Ownership and pointer update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q <= reset_own;
            ptr   <= '0;
        end else begin
            own_q <= (own_q || take) && !handoff;
            if (rewind)      ptr <= '0;
            else if (en)     ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

    // R6 R7
    drop_after_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        handoff |=> !own_q);

    // R5
    ptr_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !rewind) |=> (ptr != $past(ptr)));

    // R10
    alone_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cascade && own_q) |=> own_q);

endmodule

// File: rtl/xo_pulse_gen.sv
// Drives the shared expansion output. A write hand-off is sent at once. A read
// hand-off raised in the same cycle is held for one cycle, so the two kinds
// never share a cycle. The output idles high.
// Assumes the requests are single-cycle pulses.
module xo_pulse_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic cascade,
    input  logic wr_handoff,
    input  logic rd_handoff,
    output logic xo_q,
    output logic kind_q
);

    logic rd_pend_q;

    // Arbitrate between hand-off kinds and register the pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xo_q      <= 1'b1;
            kind_q    <= 1'b0;
            rd_pend_q <= 1'b0;
        end else if (wr_handoff) begin
            xo_q      <= 1'b0;
            kind_q    <= 1'b1;
            rd_pend_q <= rd_pend_q || rd_handoff;
        end else if (rd_handoff || rd_pend_q) begin
            xo_q      <= 1'b0;
            kind_q    <= 1'b0;
            rd_pend_q <= 1'b0;
        end else begin
            xo_q      <= 1'b1;
            kind_q    <= 1'b0;
        end
    end

    // R6
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_handoff |=> (!xo_q && kind_q));

    // R7
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_handoff && !wr_handoff && !rd_pend_q) |=> (!xo_q && !kind_q));

    // R9
    defer_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_handoff && rd_handoff) |=> ##1 (!xo_q && !kind_q));

    // R10
    alone_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cascade |-> xo_q);

endmodule

// File: rtl/cascade_token_ctrl.sv
// Token steering for one FIFO slice on a shared strobe/data ring.
// It latches the role during reset, owns or passes the write and read tokens,
// produces local enables and addresses, and shares one output pin between the
// hand-off pulse (cascade) and active-low half-full (standalone).
// Assumes strobes are synchronous to clk and used legally (no write when the
// ring is full, no read when it is empty) and DEPTH >= 2.
module cascade_token_ctrl
    import cascade_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xi_n,
    input  logic          xi_kind,
    input  logic          lead_n,
    input  logic          wr_stb,
    input  logic          rd_stb,
    input  logic          half_full,
    output logic          wr_en,
    output logic          rd_en,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic          xo_hf_n,
    output logic          xo_kind,
    output logic [1:0]    mode
);

    slice_role_e role_q, role_pins;
    logic cascade, reset_own, take_wr, take_rd, rewind;
    logic wr_handoff, rd_handoff, xo_q, kind_q;

    cascade_role_latch u_role (
        .clk      (clk),
        .rst_n    (rst_n),
        .xi_n     (xi_n),
        .lead_n   (lead_n),
        .role_q   (role_q),
        .role_pins(role_pins)
    );

    // Role-derived controls and incoming token decode
    always_comb begin
        cascade   = (role_q != ROLE_ALONE);
        reset_own = (role_pins != ROLE_TAIL);
        take_wr   = cascade && !xi_n && xi_kind;
        take_rd   = cascade && !xi_n && !xi_kind;
        rewind    = !cascade && !lead_n;
    end

    token_slot #(.DEPTH(DEPTH)) u_wr_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .cascade  (cascade),
        .reset_own(reset_own),
        .rewind   (1'b0),
        .stb      (wr_stb),
        .take     (take_wr),
        .en       (wr_en),
        .ptr      (wr_ptr),
        .handoff  (wr_handoff)
    );

    token_slot #(.DEPTH(DEPTH)) u_rd_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .cascade  (cascade),
        .reset_own(reset_own),
        .rewind   (rewind),
        .stb      (rd_stb),
        .take     (take_rd),
        .en       (rd_en),
        .ptr      (rd_ptr),
        .handoff  (rd_handoff)
    );

    xo_pulse_gen u_xo (
        .clk       (clk),
        .rst_n     (rst_n),
        .cascade   (cascade),
        .wr_handoff(wr_handoff),
        .rd_handoff(rd_handoff),
        .xo_q      (xo_q),
        .kind_q    (kind_q)
    );

    // Shared pin: hand-off pulse in cascade, inverted half-full standalone
    always_comb begin
        xo_hf_n = cascade ? xo_q : !half_full;
        xo_kind = kind_q;
        mode    = role_q;
    end

    // R3
    xo_idle_after_reset_chk: assert property (@(posedge clk)
        !rst_n |=> xo_q);

    // R3
    no_enable_in_reset_chk: assert property (@(posedge clk)
        !rst_n |-> (!wr_en && !rd_en));

    // R11
    rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rewind |=> (rd_ptr == '0 && $stable(wr_ptr)));

endmodule

// File: tb/cascade_token_ctrl_bench.sv
`timescale 1ns/100ps
module cascade_token_ctrl_bench;

    localparam int N     = 3;
    localparam int DEPTH = 4;
    localparam int AW    = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_stb = 1'b0, rd_stb = 1'b0;
    logic head_lead_n = 1'b0;
    logic ring_hf = 1'b0;

    logic [N-1:0]  r_wen, r_ren, r_xo, r_kind;
    logic [AW-1:0] r_wp [N];
    logic [AW-1:0] r_rp [N];
    logic [1:0]    r_mode [N];

    logic sa_xi_n = 1'b0, sa_lead_n = 1'b1, sa_hf = 1'b0;
    logic sa_wen, sa_ren, sa_xo, sa_kind;
    logic [AW-1:0] sa_wp, sa_rp;
    logic [1:0] sa_mode;

    int checks = 0, errors = 0;
    int mem [N][DEPTH];
    int fifo_q [$];
    int wdata = 100;
    bit done = 0;

    always #2.5 clk = ~clk;

    for (genvar g = 0; g < N; g++) begin : g_ring
        cascade_token_ctrl #(.DEPTH(DEPTH)) u_slice (
            .clk(clk), .rst_n(rst_n),
            .xi_n(r_xo[(g+N-1)%N]), .xi_kind(r_kind[(g+N-1)%N]),
            .lead_n(g == 0 ? head_lead_n : 1'b1),
            .wr_stb(wr_stb), .rd_stb(rd_stb), .half_full(ring_hf),
            .wr_en(r_wen[g]), .rd_en(r_ren[g]),
            .wr_ptr(r_wp[g]), .rd_ptr(r_rp[g]),
            .xo_hf_n(r_xo[g]), .xo_kind(r_kind[g]), .mode(r_mode[g])
        );
    end

    cascade_token_ctrl #(.DEPTH(DEPTH)) u_cascade_token_ctrl (
        .clk(clk), .rst_n(rst_n), .xi_n(sa_xi_n), .xi_kind(1'b0),
        .lead_n(sa_lead_n), .wr_stb(wr_stb), .rd_stb(rd_stb), .half_full(sa_hf),
        .wr_en(sa_wen), .rd_en(sa_ren), .wr_ptr(sa_wp), .rd_ptr(sa_rp),
        .xo_hf_n(sa_xo), .xo_kind(sa_kind), .mode(sa_mode)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One ring cycle: drive strobes, check one-hot enables, model storage
    task automatic cyc(input bit w, input bit r);
        @(negedge clk);
        wr_stb = w; rd_stb = r;
        #1;
        chk($countones(r_wen) == int'(w), "R5 write one-hot", $countones(r_wen), int'(w));
        chk($countones(r_ren) == int'(r), "R5 read one-hot", $countones(r_ren), int'(r));
        for (int i = 0; i < N; i++) begin
            if (r_wen[i]) begin
                mem[i][r_wp[i]] = wdata;
                fifo_q.push_back(wdata);
                wdata++;
            end
        end
        for (int i = 0; i < N; i++) begin
            if (r_ren[i] && fifo_q.size() > 0) begin
                int exp_v = fifo_q.pop_front();
                chk(mem[i][r_rp[i]] == exp_v, "R8 order", mem[i][r_rp[i]], exp_v);
            end
        end
        @(posedge clk); #1;
        wr_stb = 0; rd_stb = 0;
    endtask

    task automatic t_reset();
        rst_n = 0; wr_stb = 1; rd_stb = 1;
        repeat (3) @(posedge clk);
        #1;
        chk(r_wen == '0 && r_ren == '0 && !sa_wen && !sa_ren, "R3 enables in reset", int'(r_wen), 0);
        chk(r_xo == '1, "R3 xo high in reset", int'(r_xo), 7);
        chk(r_mode[0] == 2'd1, "R1 head", r_mode[0], 1);
        chk(r_mode[1] == 2'd2 && r_mode[2] == 2'd2, "R1 tail", r_mode[1], 2);
        chk(sa_mode == 2'd0, "R1 standalone", sa_mode, 0);
        @(negedge clk); wr_stb = 0; rd_stb = 0; rst_n = 1;
        @(posedge clk); #1;
    endtask

    task automatic t_fill_drain();
        for (int k = 0; k < N*DEPTH; k++) begin
            @(negedge clk); wr_stb = 1; #1;
            chk(r_wen[k/DEPTH], "R4 R8 write owner", int'(r_wen), 1 << (k/DEPTH));
            wr_stb = 0;
            cyc(1, 0);
            for (int i = 0; i < N; i++) begin
                bit low = (k % DEPTH == DEPTH-1) && (i == k/DEPTH);
                chk(r_xo[i] == !low, "R6 write hand-off", r_xo[i], !low);
                if (low) chk(r_kind[i], "R6 kind", r_kind[i], 1);
            end
        end
        for (int k = 0; k < N*DEPTH; k++) begin
            @(negedge clk); rd_stb = 1; #1;
            chk(r_ren[k/DEPTH], "R4 R8 read owner", int'(r_ren), 1 << (k/DEPTH));
            rd_stb = 0;
            cyc(0, 1);
            for (int i = 0; i < N; i++) begin
                bit low = (k % DEPTH == DEPTH-1) && (i == k/DEPTH);
                chk(r_xo[i] == !low, "R7 read hand-off", r_xo[i], !low);
                if (low) chk(!r_kind[i], "R7 kind", r_kind[i], 0);
            end
        end
        chk(fifo_q.size() == 0, "R8 drained", fifo_q.size(), 0);
    endtask

    task automatic t_interleave();
        cyc(1, 0); cyc(1, 0);
        for (int k = 0; k < 10; k++) cyc(1, 1);
        cyc(0, 1); cyc(0, 1);
        chk(fifo_q.size() == 0, "R8 interleave drained", fifo_q.size(), 0);
    endtask

    task automatic t_collision();
        for (int k = 0; k < DEPTH-1; k++) cyc(1, 1);
        cyc(1, 1);
        chk(!r_xo[0] && r_kind[0], "R9 write first", {r_xo[0], r_kind[0]}, 1);
        @(negedge clk); #1;
        chk(r_wen == '0, "R9 write token moved", int'(r_wen), 0);
        @(posedge clk); #1;
        chk(!r_xo[0] && !r_kind[0], "R9 read second", {r_xo[0], r_kind[0]}, 0);
        @(posedge clk); #1;
        chk(r_xo[0], "R9 idle after", r_xo[0], 1);
        @(negedge clk); wr_stb = 1; rd_stb = 1; #1;
        chk(r_wen == 3'b010 && r_ren == 3'b010, "R9 both at next slice", int'(r_wen), 2);
        wr_stb = 0; rd_stb = 0;
    endtask

    task automatic t_cascade_pins();
        logic [AW-1:0] rp0;
        rp0 = r_rp[0];
        @(negedge clk); head_lead_n = 1; ring_hf = 1;
        repeat (3) @(posedge clk); #1;
        chk(r_mode[0] == 2'd1, "R2 head role held", r_mode[0], 1);
        chk(r_rp[0] == rp0, "R12 no rewind", r_rp[0], rp0);
        chk(r_xo == '1, "R12 hf ignored", int'(r_xo), 7);
    endtask

    task automatic t_standalone();
        @(negedge clk); sa_xi_n = 1; sa_hf = 1; #1;
        chk(!sa_xo, "R10 hf pin", sa_xo, 0);
        @(posedge clk); #1;
        chk(sa_mode == 2'd0, "R2 standalone held", sa_mode, 0);
        sa_hf = 0; #1;
        chk(sa_xo, "R10 hf pin low", sa_xo, 1);
        // bring pointers to a known point
        while (sa_wp != 0) cyc(1, 0);
        while (sa_rp != 0) cyc(0, 1);
        for (int k = 0; k < DEPTH + 1; k++) begin
            @(negedge clk); wr_stb = 1; #1;
            chk(sa_wen, "R10 write enable", sa_wen, 1);
            @(posedge clk); #1; wr_stb = 0;
            chk(sa_xo, "R10 no pulse", sa_xo, 1);
        end
        chk(sa_wp == 1, "R10 wrap", sa_wp, 1);
        cyc(0, 1); cyc(0, 1);
        chk(sa_rp == 2, "R10 read advance", sa_rp, 2);
        @(negedge clk); sa_lead_n = 0; rd_stb = 1;
        @(posedge clk); #1; sa_lead_n = 1; rd_stb = 0;
        chk(sa_rp == 0, "R11 rewind", sa_rp, 0);
        chk(sa_wp == 1, "R11 wr kept", sa_wp, 1);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_fill_drain();
        t_interleave();
        t_collision();
        t_cascade_pins();
        t_standalone();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule